// File: doc/BRIEF.md
# Key-Armed Watchdog with Stretched Reset Output

This block guards a microcontroller core against runaway software. It leaves reset idle and counts nothing until software stores a two-byte key into one special-function-register address. Once armed, a counter advances once per machine cycle. If software does not repeat the key before the counter wraps, the block raises an internal reset request and drives the reset pin high for a fixed number of oscillator periods. A separate control input can keep the pin quiet while the internal reset still happens.

The block also qualifies the external reset pin. The pin is synchronised first. A reset is accepted only after the pin has been seen high on two machine-cycle ticks. After that the reset request stays high for as long as the pin does. The clock is the oscillator clock, and `mc_en_i` marks the one oscillator cycle in each machine cycle (one in twelve in normal use).

Top module: `wdog_keyed`

## Requirements
- R1: After `rst_ni` is released the watchdog is idle. `rst_req_o` and `rst_pin_o` are 0, and with no key written no timeout ever occurs.
- R2: The watchdog arms when an SFR write of 8'h1E to address 8'hA6 is followed directly by an SFR write of 8'hE1 to address 8'hA6. The second write clears the count to zero.
- R3: The sequence is aborted by any SFR write between the two key bytes, by E1h before 1Eh, or by E1h sent to another address. None of these arms the block. Writing 1Eh again while a sequence is pending restarts the pending sequence.
- R4: The counter is 14 bits wide and advances only on clocks where `mc_en_i` is 1. A timeout occurs on the 16384th tick after the edge that took the arming or refresh write.
- R5: Once armed, no SFR write disarms the block. Repeating the full key sequence clears the count, so the timeout moves to 16384 ticks after that write.
- R6: On timeout, `rst_req_o` is 1 for exactly 98 clock cycles, starting the cycle after the overflow edge.
- R7: While `rst_out_dis_i` is 0, `rst_pin_o` follows the timeout stretch. While it is 1, `rst_pin_o` stays 0 and `rst_req_o` still pulses.
- R8: Any reset request disarms the watchdog. After a timeout, nothing further happens until the key is written again.
- R9: `ext_rst_i` passes through two synchroniser flops. It raises `rst_req_o` after the synchronised level has been 1 on two `mc_en_i` ticks, and a single tick is not enough. The request holds while the pin is high and drops once the synchronised level goes low.
- R10: An external reset never drives `rst_pin_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mc_en_i | input | 1 | Machine-cycle tick, one clock wide |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_addr_i | input | 8 | SFR write address |
| sfr_wdata_i | input | 8 | SFR write data |
| ext_rst_i | input | 1 | Level seen on the reset pin |
| rst_out_dis_i | input | 1 | 1 keeps the pin from being driven on timeout |
| rst_req_o | output | 1 | Internal reset request |
| rst_pin_o | output | 1 | Value driven onto the reset pin |

## Verification
The bench targets the key sequencer's edges: an unrelated write between the key bytes, the bytes in reverse order, the second byte at the wrong address, a repeated first byte, and a stray write after arming. A sequencer that ignored interleaved writes or matched only on data would arm on the abort cases, and one that cleared the enable on any write would miss the timeout. The timeout is checked to the exact tick after a refresh and after a stall in `mc_en_i`, so an off-by-one counter or a count that runs on every clock shows up as an early or late request. The stretch length, the pin-disable input, re-arming after a timeout, and a one-tick external pulse are each probed. A wrong stretch count, a pin driven while disabled, a watchdog that survives its own reset, or an external filter that fires too soon each breaks a check.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;
  typedef enum logic {
    KEY_IDLE,
    KEY_HALF
  } key_state_e;
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_keyed_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_LO = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_HI = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              kick_o
);
  key_state_e state_q, state_d;
  logic hit;

  assign hit = we_i && (addr_i == REG_ADDR);

  always_comb begin
    kick_o  = 1'b0;
    state_d = state_q;
    if (clr_i) begin
      state_d = KEY_IDLE;
    end else if (we_i) begin
      // any write that is not the expected next byte drops the pending sequence
      if (hit && data_i == KEY_LO) begin
        state_d = KEY_HALF;
      end else begin
        state_d = KEY_IDLE;
        kick_o  = (state_q == KEY_HALF) && hit && (data_i == KEY_HI);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/wdog_tick_cnt.sv
module wdog_tick_cnt #(
  parameter int unsigned CNT_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic kick_i,
  input  logic tick_i,
  output logic armed_o,
  output logic ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  assign armed_o = armed_q;
  assign ovf_o   = armed_q && tick_i && (&cnt_q) && !kick_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (kick_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (ovf_o) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int unsigned LEN = 98
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o
);
  localparam int unsigned W = $clog2(LEN + 1);
  localparam logic [W-1:0] LEN_L = W'(LEN);

  logic [W-1:0] left_q;

  assign active_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        left_q <= '0;
    else if (load_i)    left_q <= LEN_L;
    else if (active_o)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/wdog_ext_qual.sv
module wdog_ext_qual #(
  parameter int unsigned TICKS       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  output logic qual_o
);
  localparam int unsigned W = $clog2(TICKS + 1);
  localparam logic [W-1:0] TICKS_L = W'(TICKS);

  logic         pin_s;
  logic [W-1:0] seen_q;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign pin_s = pin_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sr_q <= '0;
        end else begin
          sr_q[0] <= pin_i;
          for (int i = 1; i < SYNC_STAGES; i++) sr_q[i] <= sr_q[i-1];
        end
      end
      assign pin_s = sr_q[SYNC_STAGES-1];
    end
  endgenerate

  assign qual_o = (seen_q == TICKS_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  seen_q <= '0;
    else if (!pin_s)              seen_q <= '0;
    else if (tick_i && !qual_o)   seen_q <= seen_q + 1'b1;
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int unsigned CNT_W       = 14,
  parameter int unsigned STRETCH     = 98,
  parameter int unsigned EXT_TICKS   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_LO   = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_HI   = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mc_en_i,
  input  logic              sfr_we_i,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic [DATA_W-1:0] sfr_wdata_i,
  input  logic              ext_rst_i,
  input  logic              rst_out_dis_i,
  output logic              rst_req_o,
  output logic              rst_pin_o
);
  logic kick, wdt_armed, wdt_ovf, wdt_hold, ext_qual;

  wdog_key_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR),
    .KEY_LO  (KEY_LO),
    .KEY_HI  (KEY_HI)
  ) i_key (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rst_req_o),
    .we_i  (sfr_we_i),
    .addr_i(sfr_addr_i),
    .data_i(sfr_wdata_i),
    .kick_o(kick)
  );

  wdog_tick_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rst_req_o),
    .kick_i (kick),
    .tick_i (mc_en_i),
    .armed_o(wdt_armed),
    .ovf_o  (wdt_ovf)
  );

  wdog_stretch #(.LEN(STRETCH)) i_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wdt_ovf),
    .active_o(wdt_hold)
  );

  wdog_ext_qual #(
    .TICKS      (EXT_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ext (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (ext_rst_i),
    .tick_i(mc_en_i),
    .qual_o(ext_qual)
  );

  assign rst_req_o = wdt_hold | ext_qual;
  assign rst_pin_o = wdt_hold & ~rst_out_dis_i;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int unsigned STRETCH = 98,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_HI   = 8'hE1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mc_en_i,
  input logic              sfr_we_i,
  input logic [ADDR_W-1:0] sfr_addr_i,
  input logic [DATA_W-1:0] sfr_wdata_i,
  input logic              rst_req_o,
  input logic              hold,
  input logic              armed,
  input logic              ext_qual
);
  localparam int unsigned RW = $clog2(STRETCH + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (hold) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  a_r6_stretch_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold) |-> run_q == RW'(STRETCH));

  a_r4_timeout_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold) |-> $past(armed) && $past(mc_en_i));

  a_r8_disarm_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(armed) |-> rst_req_o || $past(rst_req_o));

  a_r2_arm_from_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed) |-> $past(sfr_we_i) && $past(sfr_addr_i) == REG_ADDR
                     && $past(sfr_wdata_i) == KEY_HI);

  a_r9_ext_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_qual) |-> $past(mc_en_i));
endmodule

bind wdog_keyed wdog_keyed_chk #(
  .STRETCH (STRETCH),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .REG_ADDR(REG_ADDR),
  .KEY_HI  (KEY_HI)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mc_en_i    (mc_en_i),
  .sfr_we_i   (sfr_we_i),
  .sfr_addr_i (sfr_addr_i),
  .sfr_wdata_i(sfr_wdata_i),
  .rst_req_o  (rst_req_o),
  .hold       (wdt_hold),
  .armed      (wdt_armed),
  .ext_qual   (ext_qual)
);

// File: tb/test_wdog_keyed.sv
`timescale 1ns/1ps
module test_wdog_keyed;
  localparam int TMO = 16384;
  localparam int STR = 98;

  logic clk = 1'b0;
  logic rst_ni, mc_en, we, ext_rst, dis;
  logic [7:0] addr, wdata;
  logic rst_req, rst_pin;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_keyed i_wdog_keyed (
    .clk_i(clk), .rst_ni(rst_ni), .mc_en_i(mc_en), .sfr_we_i(we),
    .sfr_addr_i(addr), .sfr_wdata_i(wdata), .ext_rst_i(ext_rst),
    .rst_out_dis_i(dis), .rst_req_o(rst_req), .rst_pin_o(rst_pin)
  );

  typedef struct packed {
    logic [2:0]      we;
    logic [2:0][7:0] addr;
    logic [2:0][7:0] data;
    logic            dis;
    logic [1:0]      kick; // slot of the arming write, 3 = none
  } vec_t;

  // slot 0 is written first; literals list slot 2 first
  localparam vec_t VEC [7] = '{
    '{3'b110, {8'hA6, 8'hA6, 8'h00}, {8'hE1, 8'h1E, 8'h00}, 1'b0, 2'd2}, // R2 plain arm
    '{3'b000, {8'h00, 8'h00, 8'h00}, {8'h00, 8'h00, 8'h00}, 1'b0, 2'd3}, // R8 idle after timeout
    '{3'b111, {8'hA6, 8'h90, 8'hA6}, {8'hE1, 8'h00, 8'h1E}, 1'b0, 2'd3}, // R3 interleaved write
    '{3'b011, {8'h00, 8'hA7, 8'hA6}, {8'h00, 8'hE1, 8'h1E}, 1'b0, 2'd3}, // R3 wrong address
    '{3'b011, {8'h00, 8'hA6, 8'hA6}, {8'h00, 8'h1E, 8'hE1}, 1'b0, 2'd3}, // R3 wrong order
    '{3'b111, {8'hA6, 8'hA6, 8'hA6}, {8'h00, 8'hE1, 8'h1E}, 1'b1, 2'd1}, // R5 stray write, R7 dis
    '{3'b111, {8'hA6, 8'hA6, 8'hA6}, {8'hE1, 8'h1E, 8'h1E}, 1'b0, 2'd2}  // R3 repeated first byte
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic en, input logic [7:0] a, input logic [7:0] d);
    we = en; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic run_quiet(input int n, output int seen);
    seen = 0;
    repeat (n) begin
      @(posedge clk); @(negedge clk);
      if (rst_req) seen++;
    end
  endtask

  task automatic expect_fire(input int remain, input logic pin_exp, input string tag);
    int seen;
    run_quiet(remain - 1, seen);
    chk({tag, " R4 no early request"}, seen, 0);
    @(posedge clk); @(negedge clk);
    chk({tag, " R4 request on tick"}, rst_req, 1'b1);
    chk({tag, " R7 pin value"}, rst_pin, pin_exp);
    repeat (STR - 1) @(posedge clk);
    @(negedge clk);
    chk({tag, " R6 still held"}, rst_req, 1'b1);
    @(posedge clk); @(negedge clk);
    chk({tag, " R6 released"}, rst_req, 1'b0);
    chk({tag, " R6 pin released"}, rst_pin, 1'b0);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R4 watchdog expired act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seen;
    rst_ni = 1'b0; mc_en = 1'b1; we = 1'b0; addr = '0; wdata = '0;
    ext_rst = 1'b0; dis = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset req", rst_req, 1'b0);
    chk("R1 reset pin", rst_pin, 1'b0);

    for (int v = 0; v < 7; v++) begin
      dis = VEC[v].dis;
      chk($sformatf("R1 vec%0d idle at start", v), rst_req, 1'b0);
      for (int s = 0; s < 3; s++) wr(VEC[v].we[s], VEC[v].addr[s], VEC[v].data[s]);
      if (VEC[v].kick != 2'd3) begin
        expect_fire(TMO - (2 - int'(VEC[v].kick)), ~VEC[v].dis, $sformatf("R2 vec%0d", v));
      end else begin
        run_quiet(TMO + 16, seen);
        chk($sformatf("R3 R8 vec%0d no timeout", v), seen, 0);
      end
    end
    dis = 1'b0;

    // R5 refresh, then R4 stall of the tick
    wr(1'b1, 8'hA6, 8'h1E);
    wr(1'b1, 8'hA6, 8'hE1);
    run_quiet(10000, seen);
    chk("R5 armed quiet", seen, 0);
    wr(1'b1, 8'hA6, 8'h1E);
    wr(1'b1, 8'hA6, 8'hE1);
    mc_en = 1'b0;
    run_quiet(500, seen);
    chk("R4 no count without tick", seen, 0);
    mc_en = 1'b1;
    expect_fire(TMO, 1'b1, "R5 refresh");

    // R9 external reset qualification, R10 pin untouched
    wr(1'b1, 8'hA6, 8'h1E);
    wr(1'b1, 8'hA6, 8'hE1);
    mc_en = 1'b0;
    ext_rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    mc_en = 1'b1;
    @(posedge clk); @(negedge clk);
    mc_en = 1'b0;
    chk("R9 one tick not enough", rst_req, 1'b0);
    repeat (11) @(posedge clk);
    @(negedge clk);
    mc_en = 1'b1;
    @(posedge clk); @(negedge clk);
    mc_en = 1'b0;
    chk("R9 second tick qualifies", rst_req, 1'b1);
    chk("R10 pin not driven", rst_pin, 1'b0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R9 held while pin high", rst_req, 1'b1);
    ext_rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 released", rst_req, 1'b0);
    mc_en = 1'b1;
    run_quiet(TMO + 16, seen);
    chk("R8 external reset disarms", seen, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule